// File: doc/BRIEF.md
# Multi-Block Flash Erase Sequencer

This block runs the automatic erase of a flash array that is split into erase blocks, each holding 8 KB of main data and 256 spare bytes. The host marks blocks in a block-select register one command at a time. It may mark any set, from a single block to every block in the array. An erase command then starts a loop. First an erase pulse is applied to all marked blocks at once. Then a single verify step checks every word line of those blocks together. When verify fails, the loop repeats, up to a pulse limit set by a parameter.

The pump and the sense circuits are outside the block. The pulse and verify phases appear as output strobes whose lengths are parameters. The verify outcome comes back on one input, which is sampled in the last verify cycle. A pulse that covers more than one block is given extra cycles. With the default parameters at 100 MHz, one block takes about 2.5 ms per pulse plus verify, and the whole array about 5 ms.

A suspend command lets a read or program run in the middle of an erase. It takes effect at the next phase boundary. The block then reports ready, and a resume command carries on with the phase that was due next. A reset command aborts everything. The ready, suspended, pass and fail flags are always visible on output pins.

Top module: `erase_ctrl`

## Requirements
- R1: Command codes on `cmd_op_i` are 0 none, 1 select, 2 erase, 3 suspend, 4 resume, 5 reset; codes 6 and 7 are ignored. A select command while idle sets bit `cmd_addr_i` of `blk_sel_o`. Bits already set stay set, so any combination of blocks can be built up.
- R2: After an accepted erase command, `erase_pulse_o` is high for a whole pulse phase. Then `verify_o` is high for exactly VERIFY_CYC cycles. The two strobes are never high together.
- R3: A pulse phase lasts PULSE_CYC cycles when one block is marked. It lasts PULSE_CYC+MULTI_EXTRA_CYC cycles when two or more distinct blocks are marked. Selecting the same block twice counts it once.
- R4: If `verify_pass_i` is high in the last verify cycle, the erase ends. `pass_o` goes to 1, `fail_o` to 0, and `ready_o` to 1.
- R5: Each failed verify issues a further pulse. After MAX_PULSES pulses with no pass, the erase ends with `fail_o`=1 and `pass_o`=0.
- R6: An erase command with no block marked issues no pulse. It sets `fail_o` and leaves the controller ready.
- R7: A suspend request during an erase does not cut the current pulse or verify phase short. At the end of that phase the controller enters suspend: `suspended_o`=1, `ready_o`=1, and both strobes low.
- R8: A resume while suspended restarts the phase that was due next. That is verify after a suspended pulse, or a fresh pulse after a failed verify. Erase and select commands are ignored while suspended.
- R9: A reset command in any state ends the erase. In the next cycle `ready_o`=1, `blk_sel_o`=0, `pass_o`=0 and `fail_o`=0.
- R10: While an erase is running, select and erase commands change neither `blk_sel_o` nor the running sequence.
- R11: Out of reset, the controller is ready and idle with all flags and strobes low and no block marked. A pending suspend is honoured within one longest phase length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 3 | Command code (see R1) |
| cmd_addr_i | input | $clog2(NBLK) | Block number for select |
| verify_pass_i | input | 1 | Verify result, sampled in last verify cycle |
| blk_sel_o | output | NBLK | Block-select register contents |
| erase_pulse_o | output | 1 | Erase pulse phase active |
| verify_o | output | 1 | Erase-verify phase active |
| ready_o | output | 1 | Controller idle or suspended |
| suspended_o | output | 1 | Erase suspended |
| pass_o | output | 1 | Last erase passed |
| fail_o | output | 1 | Last erase failed |

## Verification
The erase loop is run over several selection patterns: one block, two scattered blocks, the whole array, and an empty set. Single and multi-block selections are told apart by the measured pulse length. Empty selections are told apart from real ones by the absence of any pulse. The verify model passes after a chosen number of pulses. This separates a first-try pass, a pass after retries, and a fail at the pulse limit. Directed runs place a suspend inside a pulse and inside a failing verify, which shows which phase resume picks up. Other directed runs send a reset mid-pulse, and select or erase commands while busy.

// File: rtl/erase_ctrl_pkg.sv
package erase_ctrl_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_SELECT  = 3'd1,
    OP_ERASE   = 3'd2,
    OP_SUSPEND = 3'd3,
    OP_RESUME  = 3'd4,
    OP_RESET   = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_VERIFY = 2'd2,
    ST_SUSP   = 2'd3
  } state_e;
endpackage

// File: rtl/erase_blk_reg.sv
module erase_blk_reg #(
  parameter int NBLK = 512,
  localparam int AW = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CW = $clog2(NBLK + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic [AW-1:0]   addr_i,
  output logic [NBLK-1:0] sel_o,
  output logic [CW-1:0]   cnt_o
);
  logic [NBLK-1:0] sel_q;
  logic [CW-1:0]   cnt_q;
  logic            new_bit;

  assign new_bit = set_i && (int'(addr_i) < NBLK) && !sel_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else if (new_bit) begin
      sel_q[addr_i] <= 1'b1;
      cnt_q         <= cnt_q + CW'(1);
    end
  end

  assign sel_o = sel_q;
  assign cnt_o = cnt_q;

  // R3
  cnt_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) == $countones(sel_q));
endmodule

// File: rtl/erase_phase_timer.sv
module erase_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - TW'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_ctrl_pkg::*;
#(
  parameter int MAX_PULSES = 4,
  localparam int PNW = $clog2(MAX_PULSES + 1)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   erase_go_i,
  input  logic   susp_req_i,
  input  logic   resume_i,
  input  logic   reset_i,
  input  logic   sel_empty_i,
  input  logic   tmr_done_i,
  input  logic   verify_pass_i,
  output state_e state_o,
  output logic   load_o,
  output logic   load_pulse_o,
  output logic   susp_pend_o,
  output logic   pass_o,
  output logic   fail_o
);
  state_e         state_q, state_d, resume_q, resume_d;
  logic [PNW-1:0] pnum_q, pnum_d;
  logic           pend_q, pend_d;
  logic           pass_q, pass_d, fail_q, fail_d;

  always_comb begin
    state_d      = state_q;
    resume_d     = resume_q;
    pnum_d       = pnum_q;
    pend_d       = pend_q;
    pass_d       = pass_q;
    fail_d       = fail_q;
    load_o       = 1'b0;
    load_pulse_o = 1'b0;
    if (susp_req_i && (state_q == ST_PULSE || state_q == ST_VERIFY)) pend_d = 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        if (erase_go_i) begin
          pass_d = 1'b0;
          fail_d = sel_empty_i;
          if (!sel_empty_i) begin
            state_d      = ST_PULSE;
            load_o       = 1'b1;
            load_pulse_o = 1'b1;
            pnum_d       = PNW'(1);
          end
        end
      end
      ST_PULSE: begin
        if (tmr_done_i) begin
          if (pend_d) begin
            state_d  = ST_SUSP;
            resume_d = ST_VERIFY;
            pend_d   = 1'b0;
          end else begin
            state_d = ST_VERIFY;
            load_o  = 1'b1;
          end
        end
      end
      ST_VERIFY: begin
        if (tmr_done_i) begin
          if (verify_pass_i) begin
            state_d = ST_IDLE;
            pass_d  = 1'b1;
            pend_d  = 1'b0;
          end else if (pnum_q == PNW'(MAX_PULSES)) begin
            state_d = ST_IDLE;
            fail_d  = 1'b1;
            pend_d  = 1'b0;
          end else begin
            pnum_d = pnum_q + PNW'(1);
            if (pend_d) begin
              state_d  = ST_SUSP;
              resume_d = ST_PULSE;
              pend_d   = 1'b0;
            end else begin
              state_d      = ST_PULSE;
              load_o       = 1'b1;
              load_pulse_o = 1'b1;
            end
          end
        end
      end
      ST_SUSP: begin
        if (resume_i) begin
          state_d      = resume_q;
          load_o       = 1'b1;
          load_pulse_o = (resume_q == ST_PULSE);
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (reset_i) begin
      state_d = ST_IDLE;
      pend_d  = 1'b0;
      pass_d  = 1'b0;
      fail_d  = 1'b0;
      pnum_d  = '0;
      load_o  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      resume_q <= ST_PULSE;
      pnum_q   <= '0;
      pend_q   <= 1'b0;
      pass_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      resume_q <= resume_d;
      pnum_q   <= pnum_d;
      pend_q   <= pend_d;
      pass_q   <= pass_d;
      fail_q   <= fail_d;
    end
  end

  assign state_o     = state_q;
  assign susp_pend_o = pend_q;
  assign pass_o      = pass_q;
  assign fail_o      = fail_q;

  // R7
  susp_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP && $past(state_q) != ST_SUSP) |-> $past(tmr_done_i));
  // R5
  pulse_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pnum_q) <= MAX_PULSES);
  // R6
  empty_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && erase_go_i && sel_empty_i && !reset_i)
      |=> (state_q == ST_IDLE && fail_q));
endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl
  import erase_ctrl_pkg::*;
#(
  parameter int NBLK            = 512,
  parameter int PULSE_CYC       = 200000,
  parameter int MULTI_EXTRA_CYC = 250000,
  parameter int VERIFY_CYC      = 50000,
  parameter int MAX_PULSES      = 4,
  localparam int AW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [2:0]      cmd_op_i,
  input  logic [AW-1:0]   cmd_addr_i,
  input  logic            verify_pass_i,
  output logic [NBLK-1:0] blk_sel_o,
  output logic            erase_pulse_o,
  output logic            verify_o,
  output logic            ready_o,
  output logic            suspended_o,
  output logic            pass_o,
  output logic            fail_o
);
  localparam int CW      = $clog2(NBLK + 1);
  localparam int LONG_P  = PULSE_CYC + MULTI_EXTRA_CYC;
  localparam int LONGEST = (LONG_P > VERIFY_CYC) ? LONG_P : VERIFY_CYC;
  localparam int TW      = $clog2(LONGEST + 1);

  op_e           op;
  state_e        state;
  logic [CW-1:0] sel_cnt;
  logic          is_sel, is_erase, is_susp, is_resume, is_reset;
  logic          load, load_pulse, tmr_done, susp_pend;
  logic [TW-1:0] load_val;

  assign op        = op_e'(cmd_op_i);
  assign is_sel    = cmd_valid_i && op == OP_SELECT;
  assign is_erase  = cmd_valid_i && op == OP_ERASE;
  assign is_susp   = cmd_valid_i && op == OP_SUSPEND;
  assign is_resume = cmd_valid_i && op == OP_RESUME;
  assign is_reset  = cmd_valid_i && op == OP_RESET;

  erase_blk_reg #(.NBLK(NBLK)) i_blk_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (is_sel && state == ST_IDLE),
    .clr_i  (is_reset),
    .addr_i (cmd_addr_i),
    .sel_o  (blk_sel_o),
    .cnt_o  (sel_cnt)
  );

  // multi-block pulses run longer to reach the whole-array timing
  always_comb begin
    if (!load_pulse)             load_val = TW'(VERIFY_CYC - 1);
    else if (sel_cnt > CW'(1))   load_val = TW'(LONG_P - 1);
    else                         load_val = TW'(PULSE_CYC - 1);
  end

  erase_phase_timer #(.TW(TW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .done_o (tmr_done)
  );

  erase_seq #(.MAX_PULSES(MAX_PULSES)) i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .erase_go_i    (is_erase),
    .susp_req_i    (is_susp),
    .resume_i      (is_resume),
    .reset_i       (is_reset),
    .sel_empty_i   (sel_cnt == '0),
    .tmr_done_i    (tmr_done),
    .verify_pass_i (verify_pass_i),
    .state_o       (state),
    .load_o        (load),
    .load_pulse_o  (load_pulse),
    .susp_pend_o   (susp_pend),
    .pass_o        (pass_o),
    .fail_o        (fail_o)
  );

  assign erase_pulse_o = (state == ST_PULSE);
  assign verify_o      = (state == ST_VERIFY);
  assign ready_o       = (state == ST_IDLE) || (state == ST_SUSP);
  assign suspended_o   = (state == ST_SUSP);

  logic [TW:0] wait_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wait_cnt_q <= '0;
    else if (susp_pend) wait_cnt_q <= wait_cnt_q + 1'b1;
    else                wait_cnt_q <= '0;
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(erase_pulse_o && verify_o));
  // R9
  reset_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_reset |=> (ready_o && blk_sel_o == '0 && !pass_o && !fail_o));
  // R10
  busy_sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(state == ST_IDLE) && cmd_valid_i && !is_reset) |=> $stable(blk_sel_o));
  // R11
  susp_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wait_cnt_q) <= LONGEST + 1);
endmodule

// File: tb/test_erase_ctrl.sv
module test_erase_ctrl;
  localparam int NB = 8;
  localparam int PC = 6;
  localparam int XC = 4;
  localparam int VC = 3;
  localparam int MP = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic [2:0]    cmd_op_i = 3'd0;
  logic [2:0]    cmd_addr_i = 3'd0;
  logic          verify_pass_i = 1'b0;
  logic [NB-1:0] blk_sel_o;
  logic          erase_pulse_o, verify_o, ready_o, suspended_o, pass_o, fail_o;

  int total = 0;
  int fails = 0;

  always #5 clk_i = ~clk_i;

  erase_ctrl #(.NBLK(NB), .PULSE_CYC(PC), .MULTI_EXTRA_CYC(XC),
               .VERIFY_CYC(VC), .MAX_PULSES(MP)) i_erase_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_addr_i, .verify_pass_i,
    .blk_sel_o, .erase_pulse_o, .verify_o, .ready_o, .suspended_o, .pass_o, .fail_o
  );

  localparam logic [7:0] V_MASK [6] = '{8'h01, 8'hFF, 8'h24, 8'h80, 8'h81, 8'h00};
  localparam int         V_NEED [6] = '{1, 1, 2, 3, 4, 1};
  localparam int         V_PULS [6] = '{1, 1, 2, 3, 3, 0};
  localparam bit         V_FAIL [6] = '{0, 0, 0, 0, 1, 1};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] addr);
    cmd_valid_i = 1'b1;
    cmd_op_i    = op;
    cmd_addr_i  = addr;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    cmd_op_i    = 3'd0;
  endtask

  task automatic select_mask(input logic [7:0] m);
    for (int b = 0; b < NB; b++) if (m[b]) cmd(3'd1, 3'(b));
  endtask

  // runs an erase to completion, counting pulses and pulse-high cycles
  task automatic run_erase(input int need, output int pulses, output int hi);
    bit prev = 1'b0;
    pulses = 0;
    hi = 0;
    verify_pass_i = 1'b0;
    cmd(3'd2, 3'd0);
    for (int c = 0; c < 400 && !ready_o; c++) begin
      if (erase_pulse_o) begin
        hi++;
        if (!prev) pulses++;
      end
      prev = erase_pulse_o;
      verify_pass_i = (pulses >= need);
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int p, h, len;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R11 reset state
    chk(ready_o && !suspended_o && !pass_o && !fail_o && !erase_pulse_o && !verify_o,
        "R11 reset flags", {ready_o, suspended_o, pass_o, fail_o}, 8);
    chk(blk_sel_o == '0, "R11 reset selection", blk_sel_o, 0);

    // vector table
    for (int v = 0; v < 6; v++) begin
      cmd(3'd5, 3'd0);
      select_mask(V_MASK[v]);
      chk(blk_sel_o == V_MASK[v], "R1 selection", blk_sel_o, V_MASK[v]);
      run_erase(V_NEED[v], p, h);
      len = ($countones(V_MASK[v]) > 1) ? PC + XC : PC;
      chk(p == V_PULS[v], "R5 pulse count", p, V_PULS[v]);
      chk(h == V_PULS[v] * len, "R3 pulse cycles", h, V_PULS[v] * len);
      chk(fail_o == V_FAIL[v] && pass_o == !V_FAIL[v], "R4 status",
          {pass_o, fail_o}, {!V_FAIL[v], V_FAIL[v]});
      if (V_MASK[v] == 8'h00) chk(ready_o && !erase_pulse_o, "R6 empty erase", p, 0);
    end

    // R3 duplicate select counts once
    cmd(3'd5, 3'd0);
    cmd(3'd1, 3'd3);
    cmd(3'd1, 3'd3);
    run_erase(1, p, h);
    chk(h == PC, "R3 duplicate select", h, PC);

    // R1 codes 6,7 ignored
    cmd(3'd6, 3'd5);
    cmd(3'd7, 3'd6);
    chk(blk_sel_o == 8'h08 && ready_o && pass_o, "R1 unused codes", blk_sel_o, 8'h08);

    // R2 verify length
    begin
      int vh = 0;
      cmd(3'd2, 3'd0);
      verify_pass_i = 1'b1;
      for (int c = 0; c < 100 && !ready_o; c++) begin
        if (verify_o) vh++;
        chk(!(verify_o && erase_pulse_o), "R2 exclusive", 1, 0);
        @(negedge clk_i);
      end
      chk(vh == VC, "R2 verify cycles", vh, VC);
    end

    // R7/R8 suspend in pulse, resume into verify
    cmd(3'd5, 3'd0);
    cmd(3'd1, 3'd2);
    verify_pass_i = 1'b1;
    cmd(3'd2, 3'd0);
    repeat (2) @(negedge clk_i);
    cmd(3'd3, 3'd0);
    chk(erase_pulse_o && !ready_o, "R7 pulse not cut", erase_pulse_o, 1);
    for (int c = 0; c < 20 && !suspended_o; c++) @(negedge clk_i);
    chk(suspended_o && ready_o && !erase_pulse_o && !verify_o, "R7 suspended",
        {suspended_o, ready_o, erase_pulse_o, verify_o}, 12);
    cmd(3'd2, 3'd0);
    cmd(3'd1, 3'd6);
    repeat (3) @(negedge clk_i);
    chk(suspended_o && blk_sel_o == 8'h04, "R8 commands ignored in suspend", blk_sel_o, 8'h04);
    cmd(3'd4, 3'd0);
    chk(verify_o, "R8 resume to verify", verify_o, 1);
    for (int c = 0; c < 20 && !ready_o; c++) @(negedge clk_i);
    chk(pass_o && !suspended_o, "R4 pass after resume", pass_o, 1);

    // R8 suspend in failing verify, resume into pulse
    verify_pass_i = 1'b0;
    cmd(3'd2, 3'd0);
    for (int c = 0; c < 20 && !verify_o; c++) @(negedge clk_i);
    cmd(3'd3, 3'd0);
    for (int c = 0; c < 20 && !suspended_o; c++) @(negedge clk_i);
    chk(suspended_o, "R7 suspend in verify", suspended_o, 1);
    cmd(3'd4, 3'd0);
    chk(erase_pulse_o, "R8 resume to pulse", erase_pulse_o, 1);
    verify_pass_i = 1'b1;
    for (int c = 0; c < 30 && !ready_o; c++) @(negedge clk_i);
    chk(pass_o, "R8 completes", pass_o, 1);

    // R10 commands while busy
    cmd(3'd5, 3'd0);
    cmd(3'd1, 3'd1);
    verify_pass_i = 1'b0;
    cmd(3'd2, 3'd0);
    cmd(3'd1, 3'd5);
    cmd(3'd2, 3'd0);
    chk(blk_sel_o == 8'h02 && erase_pulse_o, "R10 select ignored", blk_sel_o, 8'h02);

    // R9 reset aborts
    cmd(3'd5, 3'd0);
    chk(ready_o && !erase_pulse_o && !verify_o && blk_sel_o == '0 && !pass_o && !fail_o,
        "R9 reset abort", blk_sel_o, 0);
    repeat (10) @(negedge clk_i);
    chk(!erase_pulse_o && !verify_o && ready_o, "R9 stays idle", erase_pulse_o, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule